// File: doc/BRIEF.md
# Secondary Cache Access Controller

This block sits between a processor core and an off-chip secondary cache made of ordinary SRAMs. It accepts one access at a time. For each access it drives a cache index and quadword position, then waits a programmed number of core cycles before it samples the returned tag, the per-line state bits (valid, shared) and the data. The SRAMs are read in a combinational loop with no handshake, so the programmed wait is the only thing that tells the controller when the returned values can be used. Writes take a programmed number of core cycles. Inside that window the write strobe has a programmed start offset and a programmed width.

The controller finishes an access on its own only when the state bits allow it. A read needs a valid line with a matching tag. A write also needs the line to be unshared, and it sets the dirty bit. In every other case the controller hands the access to an external memory-system state machine. It does this through a request code and two acknowledges. All of them run on a system clock that the block itself produces by dividing the core clock. A 32-byte line moves as two beats of 128 bits in wide mode, or as four beats of 64 bits in narrow mode. When the cache-present input is low, every access goes straight to the external request path.

Top module: `ext_cache_ctrl`

## Requirements
- R1: A read whose line is valid and whose stored tag equals the request tag completes locally, whether or not the line is shared. `line_o` then holds the four quadwords of the line, quadword q at bits [64q+63:64q], and `done_o` pulses for one core cycle.
- R2: Each cache beat keeps `c_index_o`/`c_qw_o` steady for `rd_lat_i` (N, 3 to 16) core cycles and samples at the end of the Nth cycle. With the request accepted at edge E0, a local read finishes with `done_o` high in the cycle after edge E0 + beats*N.
- R3: A local write probes for N cycles and then runs a write phase of `wr_total_i` (T) cycles. `c_we_o` is high in write-phase cycles `wr_start_i` (S) up to S+`wr_width_i`-1, and `done_o` follows edge E0+N+T. S+W must not exceed T.
- R4: A write completes locally only if the line is valid, its tag matches and it is not shared. During the strobe, `c_wdata_o` carries the quadword in both 64-bit halves at the requested quadword position, and `c_dirty_o` is 1, which sets the line's dirty bit.
- R5: When `wide_bus_i`=1, a line takes two beats; beat k reads quadwords 2k (pins [63:0]) and 2k+1 (pins [127:64]). When `wide_bus_i`=0, a line takes four beats; beat k reads quadword k on pins [63:0].
- R6: `sys_clk_o` has a period of `sys_div_i` (D, 2 to 8) core cycles and is high for the first floor(D/2) of them. `sys_req_o` changes only at the core edge where `sys_clk_o` rises, and both acknowledges are sampled at that same edge.
- R7: An access that does not complete locally raises `sys_req_o` at a system-clock rising edge: 1 for a block read, 2 for a block write, 0 when idle. It also presents the line address, the quadword and the instruction/data flag. The code stays constant until `sys_done_ack_i` is sampled; at that edge the code returns to 0 and `done_o` pulses.
- R8: On an external read, each sampled `sys_rd_ack_i` stores one beat from `sys_data_i` in order, using the R5 slot layout. Any number of idle system cycles may separate the beats.
- R9: With `cache_present_i`=0, every read and write goes to the external path, and `c_we_o` is never asserted.
- R10: A write to an invalid, shared or tag-mismatched line issues code 2, asserts no strobe and leaves the dirty bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_present_i | input | 1 | Secondary cache fitted |
| wide_bus_i | input | 1 | 1: 128-bit data pins, 0: 64-bit |
| rd_lat_i | input | CNT_W | Read access time N in core cycles |
| wr_total_i | input | CNT_W | Write phase length T |
| wr_start_i | input | CNT_W | Strobe start offset S |
| wr_width_i | input | CNT_W | Strobe width W |
| sys_div_i | input | DIV_W | System clock divider D |
| req_valid_i | input | 1 | Access request, accepted when idle |
| req_write_i | input | 1 | 1 for write |
| req_istream_i | input | 1 | Instruction-stream flag |
| req_qaddr_i | input | ADDR_W-3 | Quadword address |
| req_wdata_i | input | QW_W | Write quadword |
| done_o | output | 1 | Access complete pulse |
| line_o | output | 4*QW_W | Read line |
| c_index_o | output | IDX_W | Cache line index |
| c_qw_o | output | 2 | Quadword within line |
| c_tag_i | input | ADDR_W-5-IDX_W | Stored tag |
| c_valid_i | input | 1 | Line valid bit |
| c_shared_i | input | 1 | Line shared bit |
| c_data_i | input | 2*QW_W | Cache data pins |
| c_we_o | output | 1 | SRAM write strobe |
| c_dirty_o | output | 1 | Dirty value written with the strobe |
| c_wdata_o | output | 2*QW_W | Cache write data |
| sys_clk_o | output | 1 | Divided system clock |
| sys_req_o | output | 2 | External request code |
| sys_addr_o | output | ADDR_W-5 | Line address of the request |
| sys_qw_o | output | 2 | Requested quadword |
| sys_istream_o | output | 1 | Instruction/data flag |
| sys_rd_ack_i | input | 1 | Read beat acknowledge |
| sys_done_ack_i | input | 1 | Transaction complete acknowledge |
| sys_data_i | input | 2*QW_W | External return data |

## Verification
Local results have fixed due cycles that the bench computes from the mode values. A read finishes B*N cycles after acceptance. A write strobe starts N+S cycles after acceptance, lasts W cycles, and the write finishes at N+T. The bench counts core edges and compares these numbers with the edge at which `done_o` or `c_we_o` is seen. External results are due at the system-clock rising edge that samples the acknowledge. The bench drives each acknowledge one time unit after a system rising edge and then checks `done_o`, `line_o` and the idle request code one time unit after the next system rising edge. The SRAM model returns garbage until the address has been steady for N cycles, so sampling early is caught as wrong data.

// File: rtl/xc_pkg.sv
package xc_pkg;
  typedef enum logic [1:0] {
    REQ_IDLE   = 2'd0,
    REQ_RD_BLK = 2'd1,
    REQ_WR_BLK = 2'd2
  } xreq_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_XWAIT,
    ST_XACT
  } st_e;
endpackage

// File: rtl/xc_sysclk.sv
module xc_sysclk #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             sys_clk_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] ph_q;

  // tick_o marks the core cycle whose closing edge is a system rising edge
  assign tick_o    = (ph_q >= div_i - DIV_W'(1));
  assign sys_clk_o = (ph_q < (div_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (tick_o) ph_q <= '0;
    else             ph_q <= ph_q + DIV_W'(1);
  end

  p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i >= DIV_W'(2)) |=> !tick_o);
endmodule

// File: rtl/xc_wr_strobe.sv
module xc_wr_strobe #(
  parameter int CNT_W = 5
) (
  input  logic             active_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             we_o
);
  logic [CNT_W:0] end_pos;

  assign end_pos = {1'b0, start_i} + {1'b0, width_i};
  assign we_o    = active_i && (cnt_i >= start_i) && ({1'b0, cnt_i} < end_pos);
endmodule

// File: rtl/xc_line_buf.sv
module xc_line_buf #(
  parameter int QW_W = 64,
  localparam int PIN_W = 2 * QW_W,
  localparam int LINE_W = 4 * QW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wide_i,
  input  logic [1:0]        beat_i,
  input  logic [PIN_W-1:0]  pins_i,
  output logic [LINE_W-1:0] line_o
);
  for (genvar s = 0; s < 4; s++) begin : g_slot
    logic            sel;
    logic [QW_W-1:0] q;

    assign sel = wide_i ? (beat_i == 2'(s / 2)) : (beat_i == 2'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          q <= '0;
      else if (we_i && sel) q <= wide_i ? pins_i[(s % 2) * QW_W +: QW_W] : pins_i[QW_W-1:0];
    end

    assign line_o[s * QW_W +: QW_W] = q;
  end

  p_beat_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wide_i) |-> (beat_i < 2'd2));
endmodule

// File: rtl/ext_cache_ctrl.sv
module ext_cache_ctrl
  import xc_pkg::*;
#(
  parameter int ADDR_W = 34,
  parameter int IDX_W  = 10,
  parameter int QW_W   = 64,
  parameter int CNT_W  = 5,
  parameter int DIV_W  = 4,
  localparam int QA_W   = ADDR_W - 3,
  localparam int LA_W   = ADDR_W - 5,
  localparam int TAG_W  = ADDR_W - 5 - IDX_W,
  localparam int PIN_W  = 2 * QW_W,
  localparam int LINE_W = 4 * QW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_present_i,
  input  logic              wide_bus_i,
  input  logic [CNT_W-1:0]  rd_lat_i,
  input  logic [CNT_W-1:0]  wr_total_i,
  input  logic [CNT_W-1:0]  wr_start_i,
  input  logic [CNT_W-1:0]  wr_width_i,
  input  logic [DIV_W-1:0]  sys_div_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_istream_i,
  input  logic [QA_W-1:0]   req_qaddr_i,
  input  logic [QW_W-1:0]   req_wdata_i,
  output logic              done_o,
  output logic [LINE_W-1:0] line_o,
  output logic [IDX_W-1:0]  c_index_o,
  output logic [1:0]        c_qw_o,
  input  logic [TAG_W-1:0]  c_tag_i,
  input  logic              c_valid_i,
  input  logic              c_shared_i,
  input  logic [PIN_W-1:0]  c_data_i,
  output logic              c_we_o,
  output logic              c_dirty_o,
  output logic [PIN_W-1:0]  c_wdata_o,
  output logic              sys_clk_o,
  output logic [1:0]        sys_req_o,
  output logic [LA_W-1:0]   sys_addr_o,
  output logic [1:0]        sys_qw_o,
  output logic              sys_istream_o,
  input  logic              sys_rd_ack_i,
  input  logic              sys_done_ack_i,
  input  logic [PIN_W-1:0]  sys_data_i
);
  st_e              st_q;
  xreq_e            xreq_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beat_q;
  logic             op_wr_q, op_ist_q, done_q;
  logic [QA_W-1:0]  op_qa_q;
  logic [QW_W-1:0]  op_wd_q;

  logic       sys_tick, tag_hit, local_ok, rd_last, wr_last, last_beat;
  logic [1:0] beat_qw;
  logic       lb_we;
  logic [PIN_W-1:0] lb_pins;

  xc_sysclk #(.DIV_W(DIV_W)) u_sysclk (
    .clk_i, .rst_ni, .div_i(sys_div_i), .sys_clk_o, .tick_o(sys_tick)
  );

  // quadword address fields: [1:0] quadword, then index, then tag
  assign c_index_o = op_qa_q[IDX_W+1:2];
  assign beat_qw   = wide_bus_i ? {beat_q[0], 1'b0} : beat_q;
  assign c_qw_o    = op_wr_q ? op_qa_q[1:0] : beat_qw;
  assign tag_hit   = c_valid_i && (c_tag_i == op_qa_q[QA_W-1:IDX_W+2]);
  assign local_ok  = op_wr_q ? (tag_hit && !c_shared_i) : tag_hit;
  assign rd_last   = (cnt_q == rd_lat_i - CNT_W'(1));
  assign wr_last   = (cnt_q == wr_total_i - CNT_W'(1));
  assign last_beat = (beat_q == (wide_bus_i ? 2'd1 : 2'd3));

  xc_wr_strobe #(.CNT_W(CNT_W)) u_strobe (
    .active_i(st_q == ST_WR), .cnt_i(cnt_q),
    .start_i(wr_start_i), .width_i(wr_width_i), .we_o(c_we_o)
  );

  assign c_dirty_o = (st_q == ST_WR);
  assign c_wdata_o = {op_wd_q, op_wd_q};

  assign lb_we = ((st_q == ST_RD) && rd_last && !op_wr_q && ((beat_q != 2'd0) || local_ok))
              || ((st_q == ST_XACT) && sys_tick && sys_rd_ack_i && !op_wr_q);
  assign lb_pins = (st_q == ST_XACT) ? sys_data_i : c_data_i;

  xc_line_buf #(.QW_W(QW_W)) u_line (
    .clk_i, .rst_ni, .we_i(lb_we), .wide_i(wide_bus_i),
    .beat_i(beat_q), .pins_i(lb_pins), .line_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      xreq_q   <= REQ_IDLE;
      cnt_q    <= '0;
      beat_q   <= '0;
      op_wr_q  <= 1'b0;
      op_ist_q <= 1'b0;
      op_qa_q  <= '0;
      op_wd_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          op_wr_q  <= req_write_i;
          op_ist_q <= req_istream_i;
          op_qa_q  <= req_qaddr_i;
          op_wd_q  <= req_wdata_i;
          cnt_q    <= '0;
          beat_q   <= '0;
          st_q     <= cache_present_i ? ST_RD : ST_XWAIT;
        end
        ST_RD: if (rd_last) begin
          cnt_q <= '0;
          if (beat_q == 2'd0 && !local_ok) st_q <= ST_XWAIT;
          else if (op_wr_q)                st_q <= ST_WR;
          else if (last_beat) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else beat_q <= beat_q + 2'd1;
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_WR: if (wr_last) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end else cnt_q <= cnt_q + CNT_W'(1);
        ST_XWAIT: if (sys_tick) begin
          xreq_q <= op_wr_q ? REQ_WR_BLK : REQ_RD_BLK;
          beat_q <= '0;
          st_q   <= ST_XACT;
        end
        ST_XACT: if (sys_tick) begin
          if (sys_rd_ack_i && !op_wr_q && !last_beat) beat_q <= beat_q + 2'd1;
          if (sys_done_ack_i) begin
            xreq_q <= REQ_IDLE;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o        = done_q;
  assign sys_req_o     = xreq_q;
  assign sys_addr_o    = op_qa_q[QA_W-1:2];
  assign sys_qw_o      = op_qa_q[1:0];
  assign sys_istream_o = op_ist_q;

  p_req_on_sys_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sys_req_o) |-> $rose(sys_clk_o));
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD && cnt_q != '0) |-> ($stable(c_index_o) && $stable(c_qw_o)));
  p_no_strobe_nocache_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_we_o |-> cache_present_i);
  p_done_req_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (sys_req_o == 2'd0));
  p_strobe_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_we_o && $past(c_we_o)) |-> ($stable(c_wdata_o) && $stable(c_qw_o)));
endmodule

// File: tb/ext_cache_ctrl_test.sv
module ext_cache_ctrl_test;
  localparam int ADDR_W = 16, IDX_W = 2, QW_W = 64;
  localparam int QA_W = ADDR_W - 3, LA_W = ADDR_W - 5, TAG_W = ADDR_W - 5 - IDX_W;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic present = 1, wide = 1;
  logic [4:0] rd_lat = 5'd3, wr_total = 5'd1, wr_start = 5'd0, wr_width = 5'd1;
  logic [3:0] div = 4'd2;
  logic req_valid = 0, req_write = 0, req_ist = 0;
  logic [QA_W-1:0] req_qa = '0;
  logic [63:0] req_wd = '0;
  logic done_o, c_we, c_dirty, sys_clk, sys_ist;
  logic [255:0] line;
  logic [IDX_W-1:0] c_idx;
  logic [1:0] c_qw, sys_req, sys_qw;
  logic [TAG_W-1:0] c_tag;
  logic c_valid, c_shared;
  logic [127:0] c_data, c_wdata, sys_data = '0;
  logic [LA_W-1:0] sys_addr;
  logic rd_ack = 0, dn_ack = 0;

  ext_cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .QW_W(QW_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cache_present_i(present), .wide_bus_i(wide),
    .rd_lat_i(rd_lat), .wr_total_i(wr_total), .wr_start_i(wr_start), .wr_width_i(wr_width),
    .sys_div_i(div), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_istream_i(req_ist), .req_qaddr_i(req_qa), .req_wdata_i(req_wd),
    .done_o(done_o), .line_o(line), .c_index_o(c_idx), .c_qw_o(c_qw), .c_tag_i(c_tag),
    .c_valid_i(c_valid), .c_shared_i(c_shared), .c_data_i(c_data), .c_we_o(c_we),
    .c_dirty_o(c_dirty), .c_wdata_o(c_wdata), .sys_clk_o(sys_clk), .sys_req_o(sys_req),
    .sys_addr_o(sys_addr), .sys_qw_o(sys_qw), .sys_istream_o(sys_ist),
    .sys_rd_ack_i(rd_ack), .sys_done_ack_i(dn_ack), .sys_data_i(sys_data)
  );

  // behavioural SRAM: data only after the address is steady for rd_lat cycles
  logic [63:0] mem [16];
  logic [TAG_W-1:0] tagm [4];
  logic vld [4], shr [4], drt [4];
  int age = 0;
  logic [3:0] prev_a = '0;
  always @(negedge clk) begin
    if ({c_idx, c_qw} != prev_a) age = 1; else age = age + 1;
    prev_a = {c_idx, c_qw};
  end
  assign c_data  = (age >= int'(rd_lat)) ?
                   (wide ? {mem[{c_idx, c_qw | 2'b01}], mem[{c_idx, c_qw & 2'b10}]}
                         : {64'hDEAD_DEAD_DEAD_DEAD, mem[{c_idx, c_qw}]})
                   : {2{64'hBAD0_BAD0_BAD0_BAD0}};
  assign c_valid  = (age >= int'(rd_lat)) && vld[c_idx];
  assign c_shared = shr[c_idx];
  assign c_tag    = tagm[c_idx];
  always @(posedge clk) if (c_we) begin
    mem[{c_idx, c_qw}] = c_wdata[63:0];
    drt[c_idx] = c_dirty;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int we_cnt = 0, we_first = -1;
  always @(negedge clk) if (c_we) begin
    if (we_cnt == 0) we_first = cyc;
    we_cnt = we_cnt + 1;
  end

  int tests = 0, fails = 0, t0 = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [QA_W-1:0] qa(input int tg, input int ix, input int q);
    return {TAG_W'(tg), IDX_W'(ix), 2'(q)};
  endfunction

  function automatic logic [127:0] xpat(input int b);
    return {64'hFACE_0000_0000_0000 + 64'(2*b+1), 64'hFACE_0000_0000_0000 + 64'(2*b)};
  endfunction

  function automatic logic [255:0] mline(input int ix);
    return {mem[ix*4+3], mem[ix*4+2], mem[ix*4+1], mem[ix*4]};
  endfunction

  task automatic issue(input bit wr, input bit ist, input logic [QA_W-1:0] a, input logic [63:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_ist = ist; req_qa = a; req_wd = wd;
    we_cnt = 0; we_first = -1;
    t0 = cyc + 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output int at);
    at = -1;
    for (int i = 0; i < 3000; i++) begin
      if (done_o) begin at = cyc; break; end
      @(negedge clk);
    end
  endtask

  // external state machine model; acks driven just after a system rising edge
  task automatic ext_serve(input logic [1:0] code, input logic [QA_W-1:0] a, input bit ist,
                           input int stall, input string req);
    bit seen = 0, held = 1;
    int nb = (code == 2'd1) ? (wide ? 2 : 4) : 1;
    logic [255:0] exp = '0;
    for (int i = 0; i < 200; i++) begin
      @(posedge sys_clk); #1;
      if (sys_req != 2'd0) begin seen = 1; break; end
    end
    chk(seen && sys_req == code, {req, " R7 code"}, 256'(sys_req), 256'(code));
    chk(sys_addr == a[QA_W-1:2] && sys_qw == a[1:0] && sys_ist == ist, {req, " R7 addr"},
        256'({sys_addr, sys_qw, sys_ist}), 256'({a, ist}));
    for (int b = 0; b < nb; b++) begin
      for (int s = 0; s < stall; s++) begin
        @(posedge sys_clk); #1;
        if (sys_req != code) held = 0;
      end
      rd_ack = (code == 2'd1); dn_ack = (b == nb - 1); sys_data = xpat(b);
      if (wide) exp[b*128 +: 128] = xpat(b); else exp[b*64 +: 64] = xpat(b)[63:0];
      @(posedge sys_clk); #1;
      rd_ack = 0; dn_ack = 0;
      if (b < nb - 1 && sys_req != code) held = 0;
    end
    chk(held, {req, " R7 code held"}, 256'(held), 256'(1));
    chk(done_o && sys_req == 2'd0, {req, " R7 done at ack edge"}, 256'({done_o, sys_req}), 256'(4));
    if (code == 2'd1) chk(line == exp, {req, " R8 line"}, line, exp);
    chk(we_cnt == 0 || code == 2'd1, {req, " R10 no strobe"}, 256'(we_cnt), 256'(0));
  endtask

  task automatic sweep_sysclk(input int d);
    int hi = 0, per = 0, last_rise = -1, ok = 1;
    bit p = sys_clk;
    for (int i = 0; i < 4 * d; i++) begin
      @(negedge clk);
      if (sys_clk && !p) begin
        if (last_rise >= 0 && cyc - last_rise != d) ok = 0;
        last_rise = cyc;
      end
      if (sys_clk) hi++;
      p = sys_clk;
    end
    per = hi;
    chk(ok == 1 && per == 4 * (d / 2), "R6 sys clock shape", 256'(per), 256'(4 * (d / 2)));
  endtask

  task automatic setup(input bit pres, input int d, input int n, input bit w);
    rst_n = 0;
    present = pres; div = 4'(d); rd_lat = 5'(n); wide = w;
    for (int i = 0; i < 16; i++) mem[i] = {32'(i * 7 + d), 32'(n * 1000 + i)};
    tagm[0] = 9'h011; vld[0] = 1; shr[0] = 0; drt[0] = 0;
    tagm[1] = 9'h022; vld[1] = 1; shr[1] = 1; drt[1] = 0;
    tagm[2] = 9'h033; vld[2] = 0; shr[2] = 0; drt[2] = 0;
    tagm[3] = 9'h1F4; vld[3] = 1; shr[3] = 0; drt[3] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!done_o && sys_req == 2'd0 && !c_we, "R7 reset idle", 256'({done_o, sys_req, c_we}), 256'(0));
  endtask

  task automatic local_read(input int tg, input int ix, input bit ist, input string req);
    int at;
    int beats = wide ? 2 : 4;
    logic [255:0] e = mline(ix);
    issue(0, ist, qa(tg, ix, 1), '0);
    wait_done(at);
    chk(at == t0 + beats * int'(rd_lat), {req, " R2 read due"}, 256'(at), 256'(t0 + beats * int'(rd_lat)));
    chk(line == e, {req, " R1 R5 line"}, line, e);
  endtask

  task automatic local_write(input int q, input int s, input int w, input int t, input logic [63:0] wd);
    int at;
    wr_start = 5'(s); wr_width = 5'(w); wr_total = 5'(t);
    issue(1, 0, qa(9'h011, 0, q), wd);
    wait_done(at);
    chk(at == t0 + int'(rd_lat) + t, "R3 write due", 256'(at), 256'(t0 + int'(rd_lat) + t));
    chk(we_first == t0 + int'(rd_lat) + s, "R3 strobe start", 256'(we_first), 256'(t0 + int'(rd_lat) + s));
    chk(we_cnt == w, "R3 strobe width", 256'(we_cnt), 256'(w));
    chk(mem[q] == wd && drt[0] == 1, "R4 data and dirty", 256'({drt[0], mem[q]}), 256'({1'b1, wd}));
  endtask

  task automatic ext_write(input int tg, input int ix, input int stall, input string req);
    bit d0 = drt[ix];
    issue(1, 0, qa(tg, ix, 3), 64'h1234_5678_9ABC_DEF0);
    ext_serve(2'd2, qa(tg, ix, 3), 0, stall, req);
    chk(drt[ix] == d0, {req, " R10 dirty kept"}, 256'(drt[ix]), 256'(d0));
  endtask

  initial begin
    int divs[3] = '{2, 3, 8};
    int lats[3] = '{3, 7, 16};
    for (int di = 0; di < 3; di++)
      for (int li = 0; li < 3; li++)
        for (int wi = 0; wi < 2; wi++) begin
          setup(1, divs[di], lats[li], wi[0]);
          sweep_sysclk(divs[di]);
          local_read(9'h011, 0, 0, "hit");
          local_read(9'h1F4, 3, 1, "hit ist");
          local_read(9'h022, 1, 0, "shared read");
          issue(0, 1, qa(9'h010, 0, 2), '0);
          ext_serve(2'd1, qa(9'h010, 0, 2), 1, di, "tag miss");
          issue(0, 0, qa(9'h033, 2, 1), '0);
          ext_serve(2'd1, qa(9'h033, 2, 1), 0, 2 - di, "invalid read");
          local_write(2, 0, 1, 1, 64'hAAAA_0000_0000_0001 + 64'(li));
          local_write(1, 2, 3, 7, 64'hBBBB_0000_0000_0002 + 64'(di));
          local_read(9'h011, 0, 0, "readback");
          ext_write(9'h022, 1, 1, "shared write");
          ext_write(9'h033, 2, 0, "invalid write");
          ext_write(9'h012, 3, 2, "tag miss write");
        end
    for (int wi = 0; wi < 2; wi++) begin
      setup(0, 4, 3, wi[0]);
      issue(0, 0, qa(9'h011, 0, 0), '0);
      ext_serve(2'd1, qa(9'h011, 0, 0), 0, 1, "R9 nocache read");
      issue(1, 0, qa(9'h011, 0, 2), 64'h5555);
      ext_serve(2'd2, qa(9'h011, 0, 2), 0, 0, "R9 nocache write");
      chk(we_cnt == 0 && drt[0] == 0, "R9 no strobe", 256'(we_cnt), 256'(0));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule